// File: doc/BRIEF.md
# Threshold Offset Programming Sequencer

This block holds the two threshold offsets that a FIFO's flag logic compares against: one sets how close to empty the "nearly empty" indication begins, the other how close to full the "nearly full" indication begins. Both offsets are 14 bits wide. After reset, and until they are first programmed, both hold 127. The block also decodes the access mode, so the FIFO core behind it receives a push or pop strobe only during normal data traffic.

There is no address input. A single configuration-mode input selects programming traffic, and the registers are then reached in a fixed alternating order. Each programming write on the write clock stores the low 14 data bits into the register that is next in turn, and the turn then passes to the other register. Readback runs on the read clock with its own alternating turn. The data output carries the selected offset in its low bits and zeros above them. The user may program one register, leave configuration mode, and come back later: the sequence continues from the same place.

Top module: `offset_prog_seq`

## Requirements
- R1: Asynchronous active-low reset sets both offsets to 127 and the data output to zero. It also points both the write turn and the read turn at the empty offset.
- R2: On a write-clock edge with cfgMode=1 and wrEn=1, dataIn[13:0] is stored into the register that has the turn. The order is empty, full, empty, and so on. The other register keeps its value.
- R3: On a write-clock edge with cfgMode=1 and wrEn=0, neither offset changes.
- R4: With cfgMode=0, wrEn=1 drives fifoWrStrobe high and rdEn=1 drives fifoRdStrobe high, both combinationally. Write-clock edges in this mode leave both offsets unchanged.
- R5: While cfgMode=1, fifoWrStrobe and fifoRdStrobe stay low whatever wrEn and rdEn do.
- R6: The write turn survives leaving configuration mode. After a partial sequence and any amount of normal traffic, the next programming write goes to the register that was next in turn.
- R7: On a read-clock edge with cfgMode=1 and rdEn=1, dataOut loads the offset that has the read turn, in the order empty, full, empty. The read turn is kept apart from the write turn.
- R8: dataIn bits 17:14 are ignored when programming, and dataOut bits 17:14 are always zero.
- R9: On a read-clock edge without a readback access (cfgMode=0 or rdEn=0), dataOut holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgMode | input | 1 | 1 = configuration traffic, 0 = normal FIFO traffic |
| wrEn | input | 1 | Write enable |
| rdEn | input | 1 | Read enable |
| dataIn | input | 18 | Write data; low 14 bits are the offset value |
| dataOut | output | 18 | Readback register, offset in the low 14 bits |
| emptyOffset | output | 14 | Current near-empty threshold |
| fullOffset | output | 14 | Current near-full threshold |
| fifoWrStrobe | output | 1 | Push strobe for the FIFO core |
| fifoRdStrobe | output | 1 | Pop strobe for the FIFO core |

## Verification
The assertions check on every edge the properties that hold one cycle at a time. Idle and normal-mode edges leave the offsets stable, and a programming write lands in exactly the register that has the turn. The readback output holds when no readback happens, its padding bits stay at zero, and the FIFO strobes stay silent in configuration mode. Only the bench scenarios can show the properties that span several cycles. These are that the alternating order carries across partial sequences and long stretches of normal traffic, that the read turn advances independently of the write turn, and that a mid-run reset brings back the defaults and restarts both sequences.

// File: rtl/offset_prog_pkg.sv
package offset_prog_pkg;

  typedef enum logic {
    SEL_EMPTY = 1'b0,
    SEL_FULL  = 1'b1
  } offSel_t;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_FIFO = 2'd1,
    OP_CFG  = 2'd2
  } accOp_t;

  // strobes from control to datapath
  typedef struct packed {
    logic    progWr;
    offSel_t wrSel;
    logic    progRd;
    offSel_t rdSel;
  } ctlStrobes_t;

  function automatic accOp_t decodeOp(input logic cfg, input logic en);
    if (!en)     return OP_IDLE;
    else if (cfg) return OP_CFG;
    else          return OP_FIFO;
  endfunction

  function automatic offSel_t nextSel(input offSel_t cur);
    return (cur == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
  endfunction

endpackage

// File: rtl/offset_prog_ctrl.sv
module offset_prog_ctrl
  import offset_prog_pkg::*;
(
  input  logic        wrClk,
  input  logic        rdClk,
  input  logic        rstN,
  input  logic        cfgMode,
  input  logic        wrEn,
  input  logic        rdEn,
  output ctlStrobes_t ctl,
  output logic        fifoWrStrobe,
  output logic        fifoRdStrobe
);

  accOp_t  wrOp;
  accOp_t  rdOp;
  offSel_t wrSelQ;
  offSel_t rdSelQ;

  always_comb begin
    wrOp = decodeOp(cfgMode, wrEn);
    rdOp = decodeOp(cfgMode, rdEn);
  end

  // write-side turn, advanced only by programming writes
  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN)              wrSelQ <= SEL_EMPTY;
    else if (wrOp == OP_CFG) wrSelQ <= nextSel(wrSelQ);
  end

  // read-side turn, kept in the read clock domain
  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)              rdSelQ <= SEL_EMPTY;
    else if (rdOp == OP_CFG) rdSelQ <= nextSel(rdSelQ);
  end

  always_comb begin
    ctl.progWr   = (wrOp == OP_CFG);
    ctl.wrSel    = wrSelQ;
    ctl.progRd   = (rdOp == OP_CFG);
    ctl.rdSel    = rdSelQ;
    fifoWrStrobe = (wrOp == OP_FIFO);
    fifoRdStrobe = (rdOp == OP_FIFO);
  end

endmodule

// File: rtl/offset_prog_dp.sv
module offset_prog_dp
  import offset_prog_pkg::*;
#(
  parameter int DATA_W  = 18,
  parameter int OFF_W   = 14,
  parameter int DEF_OFF = 127
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic [OFF_W-1:0]  emptyOffset,
  output logic [OFF_W-1:0]  fullOffset
);

  localparam int PAD_W  = DATA_W - OFF_W;
  localparam int NUM_OFF = 2;
  localparam logic [OFF_W-1:0] DEF_VAL = OFF_W'(DEF_OFF);

  logic [OFF_W-1:0] offReg [NUM_OFF];
  logic [OFF_W-1:0] rdPick;

  for (genvar i = 0; i < NUM_OFF; i++) begin : g_off
    always_ff @(posedge wrClk or negedge rstN) begin
      if (!rstN)
        offReg[i] <= DEF_VAL;
      else if (ctl.progWr && (int'(ctl.wrSel) == i))
        offReg[i] <= dataIn[OFF_W-1:0];
    end
  end

  always_comb rdPick = offReg[int'(ctl.rdSel)];

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)            dataOut <= '0;
    else if (ctl.progRd)  dataOut <= {{PAD_W{1'b0}}, rdPick};
  end

  always_comb begin
    emptyOffset = offReg[int'(SEL_EMPTY)];
    fullOffset  = offReg[int'(SEL_FULL)];
  end

endmodule

// File: rtl/offset_prog_seq.sv
module offset_prog_seq
  import offset_prog_pkg::*;
#(
  parameter int DATA_W  = 18,
  parameter int OFF_W   = 14,
  parameter int DEF_OFF = 127
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              cfgMode,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic [OFF_W-1:0]  emptyOffset,
  output logic [OFF_W-1:0]  fullOffset,
  output logic              fifoWrStrobe,
  output logic              fifoRdStrobe
);

  ctlStrobes_t ctl;
  logic        wrTurnFull;

  offset_prog_ctrl u_ctrl (
    .wrClk        (wrClk),
    .rdClk        (rdClk),
    .rstN         (rstN),
    .cfgMode      (cfgMode),
    .wrEn         (wrEn),
    .rdEn         (rdEn),
    .ctl          (ctl),
    .fifoWrStrobe (fifoWrStrobe),
    .fifoRdStrobe (fifoRdStrobe)
  );

  offset_prog_dp #(
    .DATA_W  (DATA_W),
    .OFF_W   (OFF_W),
    .DEF_OFF (DEF_OFF)
  ) u_dp (
    .wrClk       (wrClk),
    .rdClk       (rdClk),
    .rstN        (rstN),
    .ctl         (ctl),
    .dataIn      (dataIn),
    .dataOut     (dataOut),
    .emptyOffset (emptyOffset),
    .fullOffset  (fullOffset)
  );

  assign wrTurnFull = (ctl.wrSel == SEL_FULL);

endmodule

// File: rtl/offset_prog_chk.sv
module offset_prog_chk #(
  parameter int DATA_W = 18,
  parameter int OFF_W  = 14
) (
  input logic              wrClk,
  input logic              rdClk,
  input logic              rstN,
  input logic              cfgMode,
  input logic              wrEn,
  input logic              rdEn,
  input logic [DATA_W-1:0] dataIn,
  input logic [DATA_W-1:0] dataOut,
  input logic [OFF_W-1:0]  emptyOffset,
  input logic [OFF_W-1:0]  fullOffset,
  input logic              fifoWrStrobe,
  input logic              fifoRdStrobe,
  input logic              wrTurnFull
);

  // R3
  cfg_idle_hold_chk: assert property (@(posedge wrClk) disable iff (!rstN)
    (cfgMode && !wrEn) |=> ($stable(emptyOffset) && $stable(fullOffset)));

  // R4
  fifo_mode_hold_chk: assert property (@(posedge wrClk) disable iff (!rstN)
    !cfgMode |=> ($stable(emptyOffset) && $stable(fullOffset)));

  // R2
  prog_empty_chk: assert property (@(posedge wrClk) disable iff (!rstN)
    (cfgMode && wrEn && !wrTurnFull) |=>
      ((emptyOffset == $past(dataIn[OFF_W-1:0])) && $stable(fullOffset)));

  // R2
  prog_full_chk: assert property (@(posedge wrClk) disable iff (!rstN)
    (cfgMode && wrEn && wrTurnFull) |=>
      ((fullOffset == $past(dataIn[OFF_W-1:0])) && $stable(emptyOffset)));

  // R9
  rd_hold_chk: assert property (@(posedge rdClk) disable iff (!rstN)
    !(cfgMode && rdEn) |=> $stable(dataOut));

  // R8
  pad_zero_chk: assert property (@(posedge rdClk) disable iff (!rstN)
    dataOut[DATA_W-1:OFF_W] == '0);

  // R5
  no_fifo_in_cfg_chk: assert property (@(posedge wrClk) disable iff (!rstN)
    cfgMode |-> (!fifoWrStrobe && !fifoRdStrobe));

endmodule

bind offset_prog_seq offset_prog_chk #(
  .DATA_W (DATA_W),
  .OFF_W  (OFF_W)
) u_chk (
  .wrClk        (wrClk),
  .rdClk        (rdClk),
  .rstN         (rstN),
  .cfgMode      (cfgMode),
  .wrEn         (wrEn),
  .rdEn         (rdEn),
  .dataIn       (dataIn),
  .dataOut      (dataOut),
  .emptyOffset  (emptyOffset),
  .fullOffset   (fullOffset),
  .fifoWrStrobe (fifoWrStrobe),
  .fifoRdStrobe (fifoRdStrobe),
  .wrTurnFull   (wrTurnFull)
);

// File: tb/offset_prog_seq_test.sv
`timescale 1ns/100ps
module offset_prog_seq_test;

  localparam int DW = 18;
  localparam int OW = 14;

  logic wrClk = 1'b0;
  logic rdClk = 1'b0;
  logic rstN = 1'b0;
  logic cfgMode = 1'b0;
  logic wrEn = 1'b0;
  logic rdEn = 1'b0;
  logic [DW-1:0] dataIn = '0;
  logic [DW-1:0] dataOut;
  logic [OW-1:0] emptyOffset, fullOffset;
  logic fifoWrStrobe, fifoRdStrobe;

  always #2 wrClk = ~wrClk;
  initial begin
    #1;
    forever #2 rdClk = ~rdClk;
  end

  offset_prog_seq uut (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .cfgMode(cfgMode),
    .wrEn(wrEn), .rdEn(rdEn), .dataIn(dataIn), .dataOut(dataOut),
    .emptyOffset(emptyOffset), .fullOffset(fullOffset),
    .fifoWrStrobe(fifoWrStrobe), .fifoRdStrobe(fifoRdStrobe)
  );

  int total = 0;
  int bad = 0;
  logic [OW-1:0] mE, mF;
  bit mWs, mRs;
  logic [DW-1:0] mOut;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] rbExpect(input bit sel, input logic [OW-1:0] e, input logic [OW-1:0] f);
    return {{(DW-OW){1'b0}}, (sel ? f : e)};
  endfunction

  function automatic bit strobeExpect(input bit cfg, input bit en);
    return !cfg && en;
  endfunction

  task automatic modelReset();
    mE = 14'd127; mF = 14'd127; mWs = 0; mRs = 0; mOut = '0;
  endtask

  task automatic wrOp(input bit cfg, input bit en, input logic [DW-1:0] d, input string req);
    @(negedge wrClk);
    cfgMode = cfg; wrEn = en; dataIn = d;
    #0.5;
    chk(fifoWrStrobe == strobeExpect(cfg, en), cfg ? "R5 wr strobe" : "R4 wr strobe",
        fifoWrStrobe, strobeExpect(cfg, en));
    @(posedge wrClk);
    if (cfg && en) begin
      if (mWs) mF = d[OW-1:0]; else mE = d[OW-1:0];
      mWs = !mWs;
    end
    #0.5;
    chk(emptyOffset == mE, req, emptyOffset, mE);
    chk(fullOffset == mF, req, fullOffset, mF);
    wrEn = 1'b0;
  endtask

  task automatic rdOp(input bit cfg, input bit en, input string req);
    @(negedge rdClk);
    cfgMode = cfg; rdEn = en;
    #0.5;
    chk(fifoRdStrobe == strobeExpect(cfg, en), cfg ? "R5 rd strobe" : "R4 rd strobe",
        fifoRdStrobe, strobeExpect(cfg, en));
    @(posedge rdClk);
    if (cfg && en) begin
      mOut = rbExpect(mRs, mE, mF);
      mRs = !mRs;
    end
    #0.5;
    chk(dataOut == mOut, req, dataOut, mOut);
    rdEn = 1'b0;
  endtask

  task automatic doReset();
    @(negedge wrClk);
    rstN = 1'b0;
    modelReset();
    #0.5;
    chk(emptyOffset == 14'd127, "R1 empty default", emptyOffset, 127);
    chk(fullOffset == 14'd127, "R1 full default", fullOffset, 127);
    chk(dataOut == '0, "R1 dataOut", dataOut, 0);
    repeat (2) @(negedge wrClk);
    rstN = 1'b1;
  endtask

  bit finished = 0;

  initial begin
    void'($urandom(32'd4242));
    modelReset();
    doReset();

    // R2 alternation, R8 upper bits ignored
    wrOp(1, 1, 18'h3C123, "R2 first->empty R8");
    wrOp(1, 1, 18'h2ABCD, "R2 second->full R8");
    wrOp(1, 1, 18'h00055, "R2 third->empty");
    // R3 cfg without enable
    wrOp(1, 0, 18'h01111, "R3 cfg idle");
    // R4 normal traffic leaves offsets
    wrOp(0, 1, 18'h03FFF, "R4 fifo write");
    wrOp(0, 0, 18'h02222, "R4 idle");
    // R6 turn persists: next prog write goes to full
    wrOp(1, 1, 18'h01357, "R6 resume->full");
    wrOp(0, 1, 18'h00001, "R6 traffic");
    wrOp(1, 1, 18'h00ACE, "R6 resume->empty");
    // R7 readback alternation, R9 hold
    rdOp(1, 1, "R7 read empty");
    rdOp(0, 1, "R9 fifo read hold");
    rdOp(1, 0, "R9 cfg idle hold");
    rdOp(1, 1, "R7 read full");
    rdOp(1, 1, "R7 read empty again");
    // R7 read turn independent: one write, then read continues its own turn
    wrOp(1, 1, 18'h03FFF, "R2 write full");
    rdOp(1, 1, "R7 read full own turn");
    // R1 mid-run reset restarts both turns
    doReset();
    wrOp(1, 1, 18'h00042, "R1 restart->empty");
    rdOp(1, 1, "R1 read restart->empty");

    // random mix
    for (int i = 0; i < 400; i++) begin
      int unsigned pick = $urandom_range(0, 5);
      logic [DW-1:0] d = DW'($urandom());
      if (pick < 3) wrOp($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, d, "R2/R3/R4 random wr");
      else if (pick < 5) rdOp($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, "R7/R9 random rd");
      else if (i % 50 == 7) doReset();
      else wrOp(0, 1, d, "R6 random traffic");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge wrClk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule